// File: doc/BRIEF.md
# Wish Loop Mode and Recovery Unit

This unit follows one predicated backward loop branch through its life in the front end. The first fetch of the loop branch fixes a confidence mode for the whole loop. In the high-confidence mode a taken prediction lets the loop predicate be speculated TRUE, so body iterations run early. In the low-confidence mode the loop still iterates as the direction predictor says, but the predicate is not speculated, and each fetched iteration waits for its predicate.

When the loop branch resolves, the unit compares the resolved position with the number of iterations fetched. It also checks whether the fall-through block was already fetched. From these it issues exactly one recovery action. An exit that came too early is flushed and re-executed. Surplus iterations fetched behind an exit that is already in flight drain as NOPs. Surplus iterations with no exit fetched yet are flushed, and fetch is redirected to the exit block. A high-confidence misprediction always flushes.

Top module: `wish_loop_recovery`

## Requirements
- R1: After reset, and whenever rst_ni is low, mode_o is 0 (idle), act_vld_o is 0 and spec_en_o is 0.
- R2: The first accepted fetch while idle sets mode_o on the following cycle: 1 (high) if fetch_hi_conf_i is set, otherwise 2 (low).
- R3: While a loop is active its mode is held. The confidence of later fetches has no effect on mode_o or on spec_en_o.
- R4: spec_en_o is high in the same cycle as a fetch exactly when the loop's mode (or, when idle, the fetch's own confidence) is high and the fetch predicts taken.
- R5: In high mode, a misprediction always gives a flush. Resolved taken on the last iteration fetched with a not-taken prediction gives act_o=1 (flush and re-execute). Resolved not-taken before that gives act_o=3 (flush and redirect to the exit).
- R6: In low mode, an early exit gives act_o=1 and act_extra_o=0. An early exit is a taken resolution of the iteration whose fetch predicted not-taken.
- R7: In low mode, a not-taken resolution with surplus iterations fetched and the fall-through already fetched gives act_o=2 (drain as NOPs). act_extra_o is then the surplus count (fetched minus resolved).
- R8: In low mode, a not-taken resolution before any predicted exit, with no fall-through fetched, gives act_o=3, and act_extra_o is the surplus count.
- R9: A not-taken resolution of the iteration predicted not-taken is a correct exit. It gives no action and returns the mode to idle.
- R10: Each loop-ending resolution raises act_vld_o for exactly one cycle, one cycle after the resolution, with mode_o already 0. A resolution while idle produces no action.
- R11: The fetched and resolved iteration counts saturate at 2^CNT_W-1. 300 taken fetches followed by a not-taken first resolution give act_extra_o = 254 with the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_vld_i | input | 1 | Loop branch fetched this cycle |
| fetch_taken_i | input | 1 | Predicted direction of the fetched loop branch |
| fetch_hi_conf_i | input | 1 | Confidence of that prediction |
| exit_fetched_i | input | 1 | Fall-through block has been fetched |
| res_vld_i | input | 1 | Loop branch instance resolves, in fetch order |
| res_taken_i | input | 1 | Resolved direction |
| mode_o | output | 2 | 0 idle, 1 high confidence, 2 low confidence |
| spec_en_o | output | 1 | Speculate loop predicate TRUE for this fetch |
| act_vld_o | output | 1 | Recovery action valid |
| act_o | output | 2 | 0 none, 1 flush and re-execute, 2 drain as NOPs, 3 flush and redirect to exit |
| act_extra_o | output | CNT_W | Surplus iterations fetched beyond the resolved one |

## Verification
The bench builds the unit with the default counter width of 8 bits, so the iteration counters saturate at 255. That is low enough for a 300-fetch loop to drive both the fetch count into saturation and the surplus count to 254 in a few hundred cycles. The same width keeps every short loop case (early, late, no exit, correct exit, both modes) well inside the count range. The surplus values there are exact differences, not clipped ones.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_HI   = 2'd1,
    MODE_LO   = 2'd2
  } wl_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_REFETCH  = 2'd1,
    ACT_DRAIN    = 2'd2,
    ACT_REDIRECT = 2'd3
  } wl_act_e;
endpackage

// File: rtl/wl_sat_cnt.sv
module wl_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_sat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && inc_i && !clr_i) |=> cnt_q == MAX);
  assert_cnt_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wl_mode_ctl.sv
module wl_mode_ctl
  import wl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fetch_vld_i,
  input  logic     fetch_taken_i,
  input  logic     fetch_hi_conf_i,
  input  logic     exit_fetched_i,
  input  logic     loop_end_i,
  output wl_mode_e mode_o,
  output logic     pred_exit_o,
  output logic     exit_seen_o,
  output logic     fetch_acc_o,
  output logic     spec_en_o
);
  wl_mode_e mode_q, mode_d;
  logic     pred_exit_q, exit_seen_q;
  logic     eff_hi;

  // fetches after a predicted exit, or racing a loop end, are not part of this loop
  assign fetch_acc_o = fetch_vld_i && !pred_exit_q && !loop_end_i;
  assign eff_hi      = (mode_q == MODE_IDLE) ? fetch_hi_conf_i : (mode_q == MODE_HI);
  assign spec_en_o   = fetch_acc_o && fetch_taken_i && eff_hi;

  always_comb begin
    mode_d = mode_q;
    if (loop_end_i)
      mode_d = MODE_IDLE;
    else if (mode_q == MODE_IDLE && fetch_acc_o)
      mode_d = fetch_hi_conf_i ? MODE_HI : MODE_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_IDLE;
      pred_exit_q <= 1'b0;
      exit_seen_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (loop_end_i) begin
        pred_exit_q <= 1'b0;
        exit_seen_q <= 1'b0;
      end else begin
        if (fetch_acc_o && !fetch_taken_i) pred_exit_q <= 1'b1;
        if (exit_fetched_i && mode_q != MODE_IDLE) exit_seen_q <= 1'b1;
      end
    end
  end

  assign mode_o      = mode_q;
  assign pred_exit_o = pred_exit_q;
  assign exit_seen_o = exit_seen_q | exit_fetched_i;

  assert_mode_pick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && fetch_acc_o) |=> mode_q != MODE_IDLE);
  assert_lo_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LO && !loop_end_i) |=> mode_q == MODE_LO);
  assert_hi_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HI && !loop_end_i) |=> mode_q == MODE_HI);
  assert_no_spec_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LO) |-> !spec_en_o);
endmodule

// File: rtl/wl_classify.sv
module wl_classify
  import wl_pkg::*;
#(
  parameter int W = 8
) (
  input  wl_mode_e     mode_i,
  input  logic         res_vld_i,
  input  logic         res_taken_i,
  input  logic [W-1:0] fetch_cnt_i,
  input  logic [W-1:0] res_cnt_i,
  input  logic         pred_exit_i,
  input  logic         exit_seen_i,
  output logic         loop_end_o,
  output logic         res_step_o,
  output wl_act_e      act_o,
  output logic [W-1:0] extra_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] r_next;
  logic         active, pred_not_taken;

  assign active         = res_vld_i && (mode_i != MODE_IDLE);
  assign r_next         = (res_cnt_i == MAX) ? MAX : res_cnt_i + 1'b1;
  // only the final fetched iteration can carry a not-taken prediction
  assign pred_not_taken = pred_exit_i && (r_next == fetch_cnt_i);

  always_comb begin
    loop_end_o = 1'b0;
    act_o      = ACT_NONE;
    extra_o    = '0;
    if (active) begin
      if (res_taken_i) begin
        if (pred_not_taken) begin
          loop_end_o = 1'b1;
          act_o      = ACT_REFETCH;
        end
      end else begin
        loop_end_o = 1'b1;
        if (!pred_not_taken) begin
          extra_o = (fetch_cnt_i > r_next) ? fetch_cnt_i - r_next : '0;
          if (mode_i == MODE_LO && exit_seen_i) act_o = ACT_DRAIN;
          else                                  act_o = ACT_REDIRECT;
        end
      end
    end
  end

  assign res_step_o = active && !loop_end_o;
endmodule

// File: rtl/wish_loop_recovery.sv
module wish_loop_recovery
  import wl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_vld_i,
  input  logic             fetch_taken_i,
  input  logic             fetch_hi_conf_i,
  input  logic             exit_fetched_i,
  input  logic             res_vld_i,
  input  logic             res_taken_i,
  output logic [1:0]       mode_o,
  output logic             spec_en_o,
  output logic             act_vld_o,
  output logic [1:0]       act_o,
  output logic [CNT_W-1:0] act_extra_o
);
  wl_mode_e         mode;
  logic             pred_exit, exit_seen, fetch_acc, loop_end, res_step;
  logic [CNT_W-1:0] fetch_cnt, res_cnt, extra_d;
  wl_act_e          act_d;

  logic             act_vld_q;
  wl_act_e          act_q;
  logic [CNT_W-1:0] extra_q;

  wl_mode_ctl u_mode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fetch_vld_i    (fetch_vld_i),
    .fetch_taken_i  (fetch_taken_i),
    .fetch_hi_conf_i(fetch_hi_conf_i),
    .exit_fetched_i (exit_fetched_i),
    .loop_end_i     (loop_end),
    .mode_o         (mode),
    .pred_exit_o    (pred_exit),
    .exit_seen_o    (exit_seen),
    .fetch_acc_o    (fetch_acc),
    .spec_en_o      (spec_en_o)
  );

  wl_sat_cnt #(.W(CNT_W)) u_fetch_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (loop_end),
    .inc_i (fetch_acc),
    .cnt_o (fetch_cnt)
  );

  wl_sat_cnt #(.W(CNT_W)) u_res_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (loop_end),
    .inc_i (res_step),
    .cnt_o (res_cnt)
  );

  wl_classify #(.W(CNT_W)) u_cls (
    .mode_i     (mode),
    .res_vld_i  (res_vld_i),
    .res_taken_i(res_taken_i),
    .fetch_cnt_i(fetch_cnt),
    .res_cnt_i  (res_cnt),
    .pred_exit_i(pred_exit),
    .exit_seen_i(exit_seen),
    .loop_end_o (loop_end),
    .res_step_o (res_step),
    .act_o      (act_d),
    .extra_o    (extra_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_vld_q <= 1'b0;
      act_q     <= ACT_NONE;
      extra_q   <= '0;
    end else begin
      act_vld_q <= loop_end && (act_d != ACT_NONE);
      act_q     <= loop_end ? act_d : ACT_NONE;
      extra_q   <= loop_end ? extra_d : '0;
    end
  end

  assign mode_o      = mode;
  assign act_vld_o   = act_vld_q;
  assign act_o       = act_q;
  assign act_extra_o = extra_q;

  assert_act_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_q |=> !act_vld_q);
  assert_idle_on_act_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_q |-> mode == MODE_IDLE);
  assert_drain_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_vld_q && act_q == ACT_DRAIN) |-> $past(mode) == MODE_LO);
  assert_idle_res_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_IDLE && res_vld_i) |=> !act_vld_q);
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!act_vld_q && mode == MODE_IDLE));
endmodule

// File: tb/tb_wish_loop_recovery.sv
`timescale 1ns/100ps
module tb_wish_loop_recovery;
  localparam int CNT_W = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fetch_vld = 0, fetch_taken = 0, fetch_hi_conf = 0, exit_fetched = 0;
  logic res_vld = 0, res_taken = 0;
  logic [1:0] mode, act;
  logic spec_en, act_vld;
  logic [CNT_W-1:0] extra;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wish_loop_recovery #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_vld_i(fetch_vld), .fetch_taken_i(fetch_taken), .fetch_hi_conf_i(fetch_hi_conf),
    .exit_fetched_i(exit_fetched), .res_vld_i(res_vld), .res_taken_i(res_taken),
    .mode_o(mode), .spec_en_o(spec_en), .act_vld_o(act_vld), .act_o(act), .act_extra_o(extra)
  );

  // hi, fetches, last fetch predicts not-taken, exit fetched, resolves, last resolve taken, act, extra
  localparam int V_HI   [NV] = '{0, 0, 0, 1, 1, 1, 0, 0};
  localparam int V_NF   [NV] = '{2, 5, 5, 5, 2, 3, 3, 1};
  localparam int V_LN   [NV] = '{1, 1, 0, 1, 1, 1, 1, 0};
  localparam int V_EXF  [NV] = '{1, 1, 0, 1, 1, 1, 1, 0};
  localparam int V_NR   [NV] = '{2, 3, 3, 3, 2, 3, 3, 1};
  localparam int V_LT   [NV] = '{1, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_ACT  [NV] = '{1, 2, 3, 3, 1, 0, 0, 3};
  localparam int V_EXT  [NV] = '{0, 2, 2, 2, 0, 0, 0, 0};
  string v_tag [NV] = '{"R6", "R7", "R8", "R5", "R5", "R9", "R9", "R8"};

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 mode in reset", mode, 0);
    chk("R1 act in reset", act_vld, 0);
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 mode after reset", mode, 0);
    chk("R1 act after reset", act_vld, 0);
    chk("R1 spec after reset", spec_en, 0);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < V_NF[v]; i++) begin
        fetch_vld     = 1;
        fetch_taken   = !(V_LN[v] == 1 && i == V_NF[v] - 1);
        fetch_hi_conf = (i == 0) ? (V_HI[v] == 1) : (V_HI[v] == 0);
        #0.5;
        chk("R4 spec", spec_en, int'(V_HI[v] == 1 && fetch_taken));
        tick();
        if (i == 0) chk("R2 mode pick", mode, V_HI[v] ? 1 : 2);
        else        chk("R3 mode held", mode, V_HI[v] ? 1 : 2);
      end
      fetch_vld = 0; fetch_taken = 0; fetch_hi_conf = 0;
      if (V_EXF[v] == 1) begin
        exit_fetched = 1;
        tick();
        exit_fetched = 0;
      end
      for (int k = 0; k < V_NR[v]; k++) begin
        res_vld   = 1;
        res_taken = (k < V_NR[v] - 1) ? 1'b1 : (V_LT[v] == 1);
        tick();
        res_vld = 0;
        if (k < V_NR[v] - 1) begin
          chk("R10 no early act", act_vld, 0);
        end else begin
          chk(v_tag[v], act_vld, int'(V_ACT[v] != 0));
          chk(v_tag[v], act, V_ACT[v]);
          chk(v_tag[v], extra, V_EXT[v]);
          chk("R10 idle at act", mode, 0);
        end
      end
      tick();
      chk("R10 single pulse", act_vld, 0);
    end

    // resolution while idle
    res_vld = 1; res_taken = 0;
    tick();
    res_vld = 0;
    chk("R10 idle resolve", act_vld, 0);

    // saturation
    for (int i = 0; i < 300; i++) begin
      fetch_vld = 1; fetch_taken = 1; fetch_hi_conf = (i != 0);
      tick();
    end
    fetch_vld = 0;
    chk("R3 low held long", mode, 2);
    res_vld = 1; res_taken = 0;
    tick();
    res_vld = 0;
    chk("R11 sat act", act, 3);
    chk("R11 sat extra", extra, 254);

    // reset mid-loop
    tick();
    fetch_vld = 1; fetch_taken = 1; fetch_hi_conf = 1;
    tick();
    fetch_vld = 0;
    chk("R2 hi mode", mode, 1);
    rst_ni = 0;
    #0.5;
    chk("R1 async reset mode", mode, 0);
    chk("R1 async reset spec", spec_en, 0);
    tick();
    rst_ni = 1;
    tick();
    chk("R1 idle after reset", mode, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule